// File: doc/BRIEF.md
# Interlock Loop Fault Classifier

This block watches a segmented low-voltage safety interlock loop through converter codes, one code per segment. At each sample strobe it sorts every segment's code into a voltage band. It then debounces the result and uses an excursion counter to separate short glitches from sustained faults and from repeated chatter. Confirmed faults are held with a per-segment fault code until an explicit clear is given.

It also tests its own sensing path. Every so often it drives a pull-up-off request for a few samples, and a healthy loop must then read low. A segment that does not respond raises a sensing fault. The combined loop-OK flag and the active-low fail-safe output go to the safe level when any segment holds a fault, when the sensing path has failed, or when a segment has not yet shown a full debounce period of healthy samples since reset. All thresholds and timings come from configuration ports.

Top module: `loop_fault_classifier`

## Requirements
- R1: Each sample is sorted into one band, checked in this priority: code <= cfgGndMax is short to ground (fault code 2), code >= cfgBatMin is short to battery (code 3), cfgOkLo..cfgOkHi inclusive is healthy, and cfgOpenLo..cfgOpenHi inclusive is open (code 1). Any other code is out of band (code 4). Fault code 0 means no fault. segFault carries 3 bits per segment, with segment 0 in bits 2:0.
- R2: A run of fault-band samples shorter than cfgDebounce ticks latches nothing. loopOk stays 1.
- R3: On the cfgDebounce-th consecutive fault-band sample, the code of the band in that sample is latched for the segment.
- R4: Each new excursion (a fault sample after a healthy one) raises the segment's event count. When the count reaches cfgEventLimit, chatter code 5 is latched on that sample.
- R5: The event count returns to zero after cfgQuietTicks consecutive healthy samples.
- R6: A latched fault in any segment drives loopOk to 0 and failSafeN to 0. The code appears only in that segment's field.
- R7: Once cfgTestPeriod normal samples have passed (0 disables the test), testPullOff rises for cfgTestLen samples. Samples taken during the pulse are not classified.
- R8: On the last pulse sample, any segment without a latched fault that reads above cfgTestMax sets senseFault. senseFault forces loopOk and failSafeN to 0.
- R9: clearReq clears a segment's latched code and event count only if that segment's last classified sample was healthy. It clears senseFault only if every segment's last sample was healthy. Otherwise it is ignored.
- R10: From reset, loopOk and failSafeN are 0 until every segment has seen cfgDebounce consecutive healthy samples.
- R11: A latched code is not overwritten by later samples until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | One-cycle strobe: sampleCodes valid |
| sampleCodes | input | NUM_SEG*CODE_W | Per-segment loop codes, segment 0 in the low bits |
| clearReq | input | 1 | Request to clear latched faults |
| cfgGndMax | input | CODE_W | Upper limit of short-to-ground band |
| cfgOkLo | input | CODE_W | Lower limit of healthy band |
| cfgOkHi | input | CODE_W | Upper limit of healthy band |
| cfgOpenLo | input | CODE_W | Lower limit of open band |
| cfgOpenHi | input | CODE_W | Upper limit of open band |
| cfgBatMin | input | CODE_W | Lower limit of short-to-battery band |
| cfgTestMax | input | CODE_W | Highest code accepted at end of test pulse |
| cfgDebounce | input | TIME_W | Debounce length in samples |
| cfgEventLimit | input | EVT_W | Excursion count that latches chatter |
| cfgQuietTicks | input | TIME_W | Healthy samples that reset the event count |
| cfgTestPeriod | input | TIME_W | Normal samples between test pulses, 0 disables |
| cfgTestLen | input | TIME_W | Test pulse length in samples |
| testPullOff | output | 1 | Pull-up removal request during self-test |
| loopOk | output | 1 | Combined loop healthy flag |
| failSafeN | output | 1 | Fail-safe output, low is safe state |
| senseFault | output | 1 | Self-test sensing fault latched |
| segFault | output | NUM_SEG*3 | Per-segment latched fault codes |

## Verification
The assertions assume sampleTick is a single-cycle strobe, that clearReq is never raised in the same cycle as a sample, and that the configuration is static while samples are flowing, except between test phases when no pulse is active. The bench drives every sample and clear from its own tasks, one strobe per two clock cycles, with clears on cycles of their own. It changes the configuration only between scenarios. During self-test it picks each segment's code from the testPullOff level seen before the strobe, as a responding or a stuck loop would.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_OPEN    = 3'd1,
    FC_GND     = 3'd2,
    FC_BAT     = 3'd3,
    FC_BAND    = 3'd4,
    FC_CHATTER = 3'd5
  } faultCode_t;

  typedef enum logic [2:0] {
    B_OK, B_OPEN, B_GND, B_BAT, B_BAND
  } band_t;

  typedef struct packed {
    logic normalTick;
    logic testTick;
    logic testLast;
    logic clearGo;
  } strobe_t;

  function automatic faultCode_t bandToCode(input band_t b);
    case (b)
      B_OPEN:  return FC_OPEN;
      B_GND:   return FC_GND;
      B_BAT:   return FC_BAT;
      B_BAND:  return FC_BAND;
      default: return FC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ilc_ctrl.sv
module ilc_ctrl
  import ilc_pkg::*;
#(
  parameter int TIME_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              clearReq,
  input  logic [TIME_W-1:0] cfgTestPeriod,
  input  logic [TIME_W-1:0] cfgTestLen,
  output strobe_t           strobe,
  output logic              testPullOff
);
  logic [TIME_W-1:0] phaseCnt;
  logic [TIME_W:0]   cntNext;
  logic              testActive;
  logic              pulseDone;

  assign cntNext   = {1'b0, phaseCnt} + 1'b1;
  assign pulseDone = cntNext >= {1'b0, cfgTestLen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt   <= '0;
      testActive <= 1'b0;
    end else if (sampleTick) begin
      if (testActive) begin
        if (pulseDone) begin
          testActive <= 1'b0;
          phaseCnt   <= '0;
        end else begin
          phaseCnt <= cntNext[TIME_W-1:0];
        end
      end else if (cfgTestPeriod == '0) begin
        phaseCnt <= '0;
      end else if (cntNext >= {1'b0, cfgTestPeriod}) begin
        testActive <= 1'b1;
        phaseCnt   <= '0;
      end else begin
        phaseCnt <= cntNext[TIME_W-1:0];
      end
    end
  end

  always_comb begin
    strobe.normalTick = sampleTick & ~testActive;
    strobe.testTick   = sampleTick & testActive;
    strobe.testLast   = sampleTick & testActive & pulseDone;
    strobe.clearGo    = clearReq;
  end

  assign testPullOff = testActive;
endmodule

// File: rtl/ilc_datapath.sv
module ilc_datapath
  import ilc_pkg::*;
#(
  parameter int NUM_SEG = 2,
  parameter int CODE_W  = 10,
  parameter int TIME_W  = 12,
  parameter int EVT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic [NUM_SEG*CODE_W-1:0] sampleCodes,
  input  logic [CODE_W-1:0]         cfgGndMax,
  input  logic [CODE_W-1:0]         cfgOkLo,
  input  logic [CODE_W-1:0]         cfgOkHi,
  input  logic [CODE_W-1:0]         cfgOpenLo,
  input  logic [CODE_W-1:0]         cfgOpenHi,
  input  logic [CODE_W-1:0]         cfgBatMin,
  input  logic [CODE_W-1:0]         cfgTestMax,
  input  logic [TIME_W-1:0]         cfgDebounce,
  input  logic [EVT_W-1:0]          cfgEventLimit,
  input  logic [TIME_W-1:0]         cfgQuietTicks,
  output logic [NUM_SEG*3-1:0]      segFault,
  output logic [NUM_SEG-1:0]        segReady,
  output logic [NUM_SEG-1:0]        segLatched,
  output logic                      senseFault
);
  localparam int FC_W = 3;

  logic [NUM_SEG-1:0] lastOkVec;
  logic [NUM_SEG-1:0] stuckVec;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [CODE_W-1:0] code;
    band_t             band;
    logic              isFault;
    logic [TIME_W-1:0] runLen, okRun, quietCnt;
    logic [TIME_W:0]   runNext, okNext, quietNext;
    logic [EVT_W-1:0]  evtCnt;
    logic [EVT_W:0]    evtNext;
    faultCode_t        latchC;
    logic              ready, lastOk, clearHere;

    assign code = sampleCodes[g*CODE_W +: CODE_W];

    always_comb begin
      if (code <= cfgGndMax)                           band = B_GND;
      else if (code >= cfgBatMin)                      band = B_BAT;
      else if (code >= cfgOkLo && code <= cfgOkHi)     band = B_OK;
      else if (code >= cfgOpenLo && code <= cfgOpenHi) band = B_OPEN;
      else                                             band = B_BAND;
    end

    assign isFault   = band != B_OK;
    assign runNext   = {1'b0, runLen} + 1'b1;
    assign okNext    = {1'b0, okRun} + 1'b1;
    assign quietNext = {1'b0, quietCnt} + 1'b1;
    assign evtNext   = {1'b0, evtCnt} + 1'b1;
    assign clearHere = strobe.clearGo & lastOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runLen   <= '0;
        okRun    <= '0;
        quietCnt <= '0;
        evtCnt   <= '0;
        latchC   <= FC_NONE;
        ready    <= 1'b0;
        lastOk   <= 1'b0;
      end else if (clearHere) begin
        latchC   <= FC_NONE;
        evtCnt   <= '0;
        runLen   <= '0;
        quietCnt <= '0;
      end else if (strobe.normalTick) begin
        lastOk <= ~isFault;
        if (isFault) begin
          okRun    <= '0;
          quietCnt <= '0;
          if (!runNext[TIME_W]) runLen <= runNext[TIME_W-1:0];
          if (runLen == '0 && !evtNext[EVT_W]) evtCnt <= evtNext[EVT_W-1:0];
          if (latchC == FC_NONE) begin
            if (runNext >= {1'b0, cfgDebounce})
              latchC <= bandToCode(band);
            else if (runLen == '0 && evtNext >= {1'b0, cfgEventLimit})
              latchC <= FC_CHATTER;
          end
        end else begin
          runLen <= '0;
          if (!okNext[TIME_W]) okRun <= okNext[TIME_W-1:0];
          if (okNext >= {1'b0, cfgDebounce}) ready <= 1'b1;
          if (!quietNext[TIME_W]) quietCnt <= quietNext[TIME_W-1:0];
          if (quietNext >= {1'b0, cfgQuietTicks}) evtCnt <= '0;
        end
      end
    end

    assign segFault[g*FC_W +: FC_W] = latchC;
    assign segReady[g]   = ready;
    assign segLatched[g] = latchC != FC_NONE;
    assign lastOkVec[g]  = lastOk;
    assign stuckVec[g]   = (latchC == FC_NONE) && (code > cfgTestMax);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  senseFault <= 1'b0;
    else if (strobe.clearGo && (&lastOkVec))    senseFault <= 1'b0;
    else if (strobe.testLast && (|stuckVec))    senseFault <= 1'b1;
  end
endmodule

// File: rtl/loop_fault_classifier.sv
module loop_fault_classifier
  import ilc_pkg::*;
#(
  parameter int NUM_SEG = 2,
  parameter int CODE_W  = 10,
  parameter int TIME_W  = 12,
  parameter int EVT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleTick,
  input  logic [NUM_SEG*CODE_W-1:0] sampleCodes,
  input  logic                      clearReq,
  input  logic [CODE_W-1:0]         cfgGndMax,
  input  logic [CODE_W-1:0]         cfgOkLo,
  input  logic [CODE_W-1:0]         cfgOkHi,
  input  logic [CODE_W-1:0]         cfgOpenLo,
  input  logic [CODE_W-1:0]         cfgOpenHi,
  input  logic [CODE_W-1:0]         cfgBatMin,
  input  logic [CODE_W-1:0]         cfgTestMax,
  input  logic [TIME_W-1:0]         cfgDebounce,
  input  logic [EVT_W-1:0]          cfgEventLimit,
  input  logic [TIME_W-1:0]         cfgQuietTicks,
  input  logic [TIME_W-1:0]         cfgTestPeriod,
  input  logic [TIME_W-1:0]         cfgTestLen,
  output logic                      testPullOff,
  output logic                      loopOk,
  output logic                      failSafeN,
  output logic                      senseFault,
  output logic [NUM_SEG*3-1:0]      segFault
);
  strobe_t            strobe;
  logic [NUM_SEG-1:0] segReady;
  logic [NUM_SEG-1:0] segLatched;

  ilc_ctrl #(.TIME_W(TIME_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .clearReq(clearReq),
    .cfgTestPeriod(cfgTestPeriod), .cfgTestLen(cfgTestLen),
    .strobe(strobe), .testPullOff(testPullOff)
  );

  ilc_datapath #(.NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .TIME_W(TIME_W), .EVT_W(EVT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleCodes(sampleCodes),
    .cfgGndMax(cfgGndMax), .cfgOkLo(cfgOkLo), .cfgOkHi(cfgOkHi),
    .cfgOpenLo(cfgOpenLo), .cfgOpenHi(cfgOpenHi), .cfgBatMin(cfgBatMin),
    .cfgTestMax(cfgTestMax), .cfgDebounce(cfgDebounce),
    .cfgEventLimit(cfgEventLimit), .cfgQuietTicks(cfgQuietTicks),
    .segFault(segFault), .segReady(segReady), .segLatched(segLatched),
    .senseFault(senseFault)
  );

  assign loopOk    = (&segReady) & ~(|segLatched) & ~senseFault;
  assign failSafeN = loopOk;
endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
  parameter int NUM_SEG = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleTick,
  input logic               clearReq,
  input logic               testPullOff,
  input logic               senseFault,
  input logic               loopOk,
  input logic               failSafeN,
  input logic [NUM_SEG*3-1:0] segFault
);
  a_r6_fault_forces_safe: assert property (@(posedge clk) disable iff (!rstN)
    (|segFault) |-> (!loopOk && !failSafeN));

  a_r7_pulse_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(testPullOff));

  a_r8_sense_fault_holds: assert property (@(posedge clk) disable iff (!rstN)
    (senseFault && !clearReq) |=> senseFault);

  a_r10_ok_rises_on_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopOk) |-> ($past(sampleTick) || $past(clearReq)));

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_sticky
    a_r11_code_sticky: assert property (@(posedge clk) disable iff (!rstN)
      ($past(segFault[g*3 +: 3]) != 3'd0 && !$past(clearReq))
        |-> segFault[g*3 +: 3] == $past(segFault[g*3 +: 3]));
  end
endmodule

bind loop_fault_classifier ilc_checker #(.NUM_SEG(NUM_SEG)) i_checker (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .clearReq(clearReq),
  .testPullOff(testPullOff), .senseFault(senseFault), .loopOk(loopOk),
  .failSafeN(failSafeN), .segFault(segFault)
);

// File: tb/test_loop_fault_classifier.sv
module test_loop_fault_classifier;
  localparam int NUM_SEG = 2;
  localparam int CODE_W  = 10;
  localparam int TIME_W  = 12;
  localparam int EVT_W   = 8;

  localparam logic [CODE_W-1:0] V_OK = 10'd400, V_OPEN = 10'd800, V_GND = 10'd10,
                                V_BAT = 10'd1010, V_BAND = 10'd600, V_PULL = 10'd80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic [NUM_SEG*CODE_W-1:0] sampleCodes = '0;
  logic clearReq = 1'b0;
  logic [CODE_W-1:0] cfgGndMax = 10'd40, cfgOkLo = 10'd300, cfgOkHi = 10'd500;
  logic [CODE_W-1:0] cfgOpenLo = 10'd700, cfgOpenHi = 10'd900, cfgBatMin = 10'd980;
  logic [CODE_W-1:0] cfgTestMax = 10'd150;
  logic [TIME_W-1:0] cfgDebounce = 12'd10, cfgQuietTicks = 12'd1000;
  logic [TIME_W-1:0] cfgTestPeriod = 12'd0, cfgTestLen = 12'd3;
  logic [EVT_W-1:0]  cfgEventLimit = 8'd3;
  logic testPullOff, loopOk, failSafeN, senseFault;
  logic [NUM_SEG*3-1:0] segFault;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  loop_fault_classifier #(.NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .TIME_W(TIME_W), .EVT_W(EVT_W))
  i_loop_fault_classifier (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .sampleCodes(sampleCodes),
    .clearReq(clearReq), .cfgGndMax(cfgGndMax), .cfgOkLo(cfgOkLo), .cfgOkHi(cfgOkHi),
    .cfgOpenLo(cfgOpenLo), .cfgOpenHi(cfgOpenHi), .cfgBatMin(cfgBatMin),
    .cfgTestMax(cfgTestMax), .cfgDebounce(cfgDebounce), .cfgEventLimit(cfgEventLimit),
    .cfgQuietTicks(cfgQuietTicks), .cfgTestPeriod(cfgTestPeriod), .cfgTestLen(cfgTestLen),
    .testPullOff(testPullOff), .loopOk(loopOk), .failSafeN(failSafeN),
    .senseFault(senseFault), .segFault(segFault)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic [CODE_W-1:0] c0, input logic [CODE_W-1:0] c1);
    @(negedge clk);
    sampleCodes = {c1, c0};
    sampleTick  = 1'b1;
    @(negedge clk);
    sampleTick  = 1'b0;
  endtask

  task automatic ticks(input int n, input logic [CODE_W-1:0] c0, input logic [CODE_W-1:0] c1);
    for (int i = 0; i < n; i++) tick(c0, c1);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
  endtask

  // R10: reset state and power-up qualification
  task automatic t_powerup();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R10 reset loopOk", loopOk, 0);
    check("R10 reset failSafeN", failSafeN, 0);
    check("R10 reset segFault", segFault, 0);
    check("R7 reset testPullOff", testPullOff, 0);
    ticks(9, V_OK, V_OK);
    check("R10 loopOk before debounce", loopOk, 0);
    tick(V_OK, V_OK);
    check("R10 loopOk after debounce", loopOk, 1);
    check("R10 failSafeN after debounce", failSafeN, 1);
  endtask

  // R2 / R3 / R6 / R11 / R9 on segment 0 open
  task automatic t_open();
    ticks(9, V_OPEN, V_OK);
    tick(V_OK, V_OK);
    check("R2 short excursion segFault", segFault, 0);
    check("R2 short excursion loopOk", loopOk, 1);
    ticks(9, V_OPEN, V_OK);
    check("R3 no latch at debounce-1", segFault, 0);
    tick(V_OPEN, V_OK);
    check("R3 open latched seg0", segFault, 1);
    check("R6 loopOk low", loopOk, 0);
    check("R6 failSafeN low", failSafeN, 0);
    tick(V_GND, V_OK);
    check("R11 code kept after band change", segFault, 1);
    pulseClear();
    check("R9 clear ignored while faulty", segFault, 1);
    tick(V_OK, V_OK);
    pulseClear();
    check("R9 clear when healthy", segFault, 0);
    check("R9 loopOk restored", loopOk, 1);
  endtask

  // R1: other bands on both segments
  task automatic t_bands();
    ticks(10, V_OK, V_GND);
    check("R1 short to ground seg1", segFault, 2 << 3);
    tick(V_OK, V_OK); pulseClear();
    ticks(10, V_BAT, V_OK);
    check("R1 short to battery seg0", segFault, 3);
    tick(V_OK, V_OK); pulseClear();
    ticks(10, V_OK, V_BAND);
    check("R1 out of band seg1", segFault, 4 << 3);
    tick(V_OK, V_OK); pulseClear();
    check("R1 all cleared", segFault, 0);
  endtask

  // R4: repeated chatter
  task automatic t_chatter();
    tick(V_OPEN, V_OK); tick(V_OK, V_OK);
    tick(V_OPEN, V_OK); tick(V_OK, V_OK);
    check("R4 two excursions no latch", segFault, 0);
    tick(V_OPEN, V_OK);
    check("R4 chatter latched", segFault, 5);
    tick(V_OK, V_OK); pulseClear();
    check("R4 chatter cleared", segFault, 0);
  endtask

  // R5: quiet window resets the event count
  task automatic t_quiet();
    tick(V_OK, V_OPEN); tick(V_OK, V_OK);
    tick(V_OK, V_OPEN);
    ticks(1000, V_OK, V_OK);
    tick(V_OK, V_OPEN); tick(V_OK, V_OK);
    tick(V_OK, V_OPEN); tick(V_OK, V_OK);
    check("R5 count reset after quiet window", segFault, 0);
    tick(V_OK, V_OPEN);
    check("R5 counting resumes", segFault, 5 << 3);
    tick(V_OK, V_OK); pulseClear();
  endtask

  // R7 / R8 / R9: self-test pulse
  task automatic t_selftest();
    cfgDebounce   = 12'd2;
    cfgTestPeriod = 12'd5;
    ticks(4, V_OK, V_OK);
    check("R7 no pulse before period", testPullOff, 0);
    tick(V_OK, V_OK);
    check("R7 pulse starts", testPullOff, 1);
    ticks(3, V_PULL, V_PULL);
    check("R7 pulse ends", testPullOff, 0);
    check("R7 pulse samples not classified", segFault, 0);
    check("R8 responding loop no sense fault", senseFault, 0);
    check("R8 loopOk after good test", loopOk, 1);
    ticks(5, V_OK, V_OK);
    check("R7 second pulse", testPullOff, 1);
    ticks(3, V_PULL, V_OK);
    check("R8 stuck segment flags", senseFault, 1);
    check("R8 loopOk low", loopOk, 0);
    check("R8 failSafeN low", failSafeN, 0);
    cfgTestPeriod = 12'd0;
    tick(V_OK, V_OK);
    pulseClear();
    check("R9 sense fault cleared", senseFault, 0);
    check("R9 loopOk after sense clear", loopOk, 1);
  endtask

  initial begin
    t_powerup();
    t_open();
    t_bands();
    t_chatter();
    t_quiet();
    t_selftest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule